// File: doc/BRIEF.md
# 16-bit PWM Compare Channel

This block is one compare channel that hangs off a shared, free-running 16-bit timebase counter. It drives a pulse-width-modulated pin. The pin is set when the timebase equals the programmed compare value and cleared when the timebase wraps. The number of timebase clocks the pin spends low therefore equals the compare value, so the duty cycle is (65536 − compare)/65536. A compare value of 0 gives a pin that is always high. A value of 0xFFFF gives a single high clock per period.

Software loads the compare value one byte at a time. Writing the low byte turns the comparator off, and writing the high byte turns it back on, so the comparator never acts on a half-written value. Leaving the comparator off (low byte written, high byte not) yields a 0% duty cycle. A sticky match flag tells software when it is safe to load the next value. The comparator reads the compare register directly, with no shadow copy.

Top module: `pwm16_cmp_chan`

## Requirements
- R1: When the comparator is active and `tb_count` equals the compare register in a cycle, `pwm_o` is high from the following cycle.
- R2: A `tb_ovf` pulse with no match in the same cycle drives `pwm_o` low from the following cycle. Otherwise `pwm_o` holds its value.
- R3: When a match and `tb_ovf` coincide (compare value 0 and `tb_count` 0x0000), the set wins, so a compare value of 0 keeps `pwm_o` high continuously.
- R4: A compare value of 0xFFFF gives exactly one high clock per period: high after the 0xFFFF cycle and low again after the wrap cycle.
- R5: `wr_lo` loads `wr_data` into compare bits 7:0 and clears the comparator enable. While the enable is clear, no match occurs, so `pwm_o` falls at the next overflow and then stays low.
- R6: `wr_hi` loads `wr_data` into compare bits 15:8 and sets the comparator enable. If both strobes arrive in the same cycle, both bytes load and the enable ends set.
- R7: A match requires the comparator enable, `mode_pwm` and `mode_wide` all to be 1. If either mode bit is 0, no match occurs.
- R8: A match sets `match_flag_o` from the following cycle only when `match_en` is 1. With `match_en` 0, the pin still follows R1 but the flag is unchanged.
- R9: `match_flag_o` is sticky until a `flag_clr` pulse clears it. A match in the same cycle as `flag_clr` leaves the flag set.
- R10: During reset, `pwm_o` and `match_flag_o` are 0, the compare register is 0 and the comparator is disabled.
- R11: A byte write takes effect on the comparison from the cycle after the strobe. The comparison in the strobe cycle still uses the old register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tb_count | input | 16 | Shared timebase counter value |
| tb_ovf | input | 1 | One-cycle pulse in the cycle the timebase shows 0x0000 after wrapping |
| wr_lo | input | 1 | Low compare byte write strobe |
| wr_hi | input | 1 | High compare byte write strobe |
| wr_data | input | 8 | Byte written by either strobe |
| mode_pwm | input | 1 | PWM mode select |
| mode_wide | input | 1 | 16-bit width select |
| match_en | input | 1 | Allows a match to set the flag |
| flag_clr | input | 1 | Clears the match flag |
| pwm_o | output | 1 | PWM output pin |
| match_flag_o | output | 1 | Sticky match flag |

## Verification
Both outputs are registered. Any input presented in one cycle shows up on `pwm_o` and `match_flag_o` exactly one edge later. A byte write changes the comparison from the following cycle on, so its first visible effect on the pins comes two edges after the strobe. The driver applies one cycle of stimulus per clock at the falling edge. It also pushes the pin and flag values predicted by a requirement-level model into a queue. The monitor pops one entry per rising edge, shortly after that edge, so every prediction is compared against the outputs produced by exactly the cycle that created it.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;

  typedef struct packed {
    logic pwm;
    logic wide;
    logic match_en;
  } chan_mode_t;
endpackage

// File: rtl/pwm16_cmp_reg.sv
module pwm16_cmp_reg #(
  parameter int BYTE_W = pwm16_pkg::BYTE_W,
  parameter int LANES  = pwm16_pkg::LANES,
  localparam int CW    = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  wr_lane,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CW-1:0]     cmp_q,
  output logic              cmp_en_q
);
  // Byte lanes: each lane has its own clock enable.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q <= '0;
      else if (wr_lane[g]) lane_q <= wr_data;
    end
    assign cmp_q[g*BYTE_W +: BYTE_W] = lane_q;
  end

  // Top lane write arms the comparator, any lower lane write disarms it.
  logic en_d, en_ce;
  always_comb begin
    en_ce = |wr_lane;
    en_d  = wr_lane[LANES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmp_en_q <= 1'b0;
    else if (en_ce) cmp_en_q <= en_d;
  end
endmodule

// File: rtl/pwm16_match.sv
module pwm16_match #(
  parameter int CW = 16
) (
  input  logic                   cmp_en,
  input  pwm16_pkg::chan_mode_t  mode,
  input  logic [CW-1:0]          count,
  input  logic [CW-1:0]          cmp,
  output logic                   hit
);
  always_comb begin
    hit = cmp_en && mode.pwm && mode.wide && (count == cmp);
  end
endmodule

// File: rtl/pwm16_out.sv
module pwm16_out (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ovf,
  input  logic flag_arm,
  input  logic flag_clr,
  output logic pwm_q,
  output logic flag_q
);
  logic pwm_d, pwm_ce, flag_d, flag_ce;

  always_comb begin
    // Set from a match outranks clear from overflow.
    pwm_ce  = hit || ovf;
    pwm_d   = hit;
    // Set from a match outranks software clear.
    flag_ce = (hit && flag_arm) || flag_clr;
    flag_d  = hit && flag_arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pwm_q <= 1'b0;
    else if (pwm_ce) pwm_q <= pwm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end
endmodule

// File: rtl/pwm16_cmp_chan.sv
module pwm16_cmp_chan #(
  parameter int BYTE_W = pwm16_pkg::BYTE_W,
  localparam int LANES = pwm16_pkg::LANES,
  localparam int CW    = BYTE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     tb_count,
  input  logic              tb_ovf,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              mode_pwm,
  input  logic              mode_wide,
  input  logic              match_en,
  input  logic              flag_clr,
  output logic              pwm_o,
  output logic              match_flag_o
);
  pwm16_pkg::chan_mode_t mode;
  logic [CW-1:0] cmp_q;
  logic          cmp_en_q;
  logic          hit;
  logic [LANES-1:0] wr_lane;

  always_comb begin
    mode.pwm      = mode_pwm;
    mode.wide     = mode_wide;
    mode.match_en = match_en;
    wr_lane       = {wr_hi, wr_lo};
  end

  pwm16_cmp_reg #(.BYTE_W(BYTE_W), .LANES(LANES)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lane  (wr_lane),
    .wr_data  (wr_data),
    .cmp_q    (cmp_q),
    .cmp_en_q (cmp_en_q)
  );

  pwm16_match #(.CW(CW)) u_match (
    .cmp_en (cmp_en_q),
    .mode   (mode),
    .count  (tb_count),
    .cmp    (cmp_q),
    .hit    (hit)
  );

  pwm16_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .ovf      (tb_ovf),
    .flag_arm (mode.match_en),
    .flag_clr (flag_clr),
    .pwm_q    (pwm_o),
    .flag_q   (match_flag_o)
  );
endmodule

// File: rtl/pwm16_cmp_chan_chk.sv
module pwm16_cmp_chan_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tb_count,
  input logic          tb_ovf,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic          mode_pwm,
  input logic          mode_wide,
  input logic          match_en,
  input logic          flag_clr,
  input logic          pwm_o,
  input logic          match_flag_o,
  input logic [CW-1:0] cmp_q,
  input logic          cmp_en_q
);
  logic active;
  always_comb active = cmp_en_q && mode_pwm && mode_wide;

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tb_count == cmp_q) |=> pwm_o); // R1

  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_ovf && !(active && tb_count == cmp_q)) |=> !pwm_o); // R2

  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmp_q == '0 && tb_count == '0 && tb_ovf) |=> pwm_o); // R3

  AST_LO_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> !cmp_en_q); // R5

  AST_DISARMED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en_q |=> !$rose(pwm_o)); // R5

  AST_HI_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cmp_en_q); // R6

  AST_MODE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mode_pwm && mode_wide) && !pwm_o) |=> !pwm_o); // R7

  AST_NO_ARM_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_en && !match_flag_o) |=> !match_flag_o); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag_o && !flag_clr) |=> match_flag_o); // R9

  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && match_en && active && tb_count == cmp_q) |=> match_flag_o); // R9

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!pwm_o && !match_flag_o && !cmp_en_q); // R10
    end
  end
endmodule

bind pwm16_cmp_chan pwm16_cmp_chan_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tb_count     (tb_count),
  .tb_ovf       (tb_ovf),
  .wr_lo        (wr_lo),
  .wr_hi        (wr_hi),
  .mode_pwm     (mode_pwm),
  .mode_wide    (mode_wide),
  .match_en     (match_en),
  .flag_clr     (flag_clr),
  .pwm_o        (pwm_o),
  .match_flag_o (match_flag_o),
  .cmp_q        (cmp_q),
  .cmp_en_q     (cmp_en_q)
);

// File: tb/tb_pwm16_cmp_chan.sv
module tb_pwm16_cmp_chan;
  logic        clk;
  logic        rst_n;
  logic [15:0] tb_count;
  logic        tb_ovf;
  logic        wr_lo, wr_hi;
  logic [7:0]  wr_data;
  logic        mode_pwm, mode_wide, match_en, flag_clr;
  logic        pwm_o, match_flag_o;

  pwm16_cmp_chan dut (
    .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_ovf(tb_ovf),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .mode_pwm(mode_pwm), .mode_wide(mode_wide), .match_en(match_en),
    .flag_clr(flag_clr), .pwm_o(pwm_o), .match_flag_o(match_flag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic  exp_pwm;
    logic  exp_flag;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_total = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  // Requirement-level reference state
  logic [15:0] m_cmp;
  logic        m_en, m_pwm, m_flag;

  task automatic check(input logic act, input logic exp, input string what);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  // Monitor: one expected item per rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      check(pwm_o, it.exp_pwm, {it.tag, " pwm"});
      check(match_flag_o, it.exp_flag, {it.tag, " flag"});
    end
  end

  // Driver: one cycle of stimulus plus its predicted outcome
  task automatic step(input logic [15:0] cnt, input logic ovf,
                      input logic lo, input logic hi, input logic [7:0] d,
                      input logic clr, input string tag);
    logic hit;
    exp_t it;
    @(negedge clk);
    tb_count = cnt; tb_ovf = ovf; wr_lo = lo; wr_hi = hi;
    wr_data = d; flag_clr = clr;
    hit = m_en && mode_pwm && mode_wide && (cnt == m_cmp);
    if (hit) m_pwm = 1'b1;
    else if (ovf) m_pwm = 1'b0;
    if (hit && match_en) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    if (lo) m_cmp[7:0] = d;
    if (hi) m_cmp[15:8] = d;
    if (hi) m_en = 1'b1;
    else if (lo) m_en = 1'b0;
    it.exp_pwm = m_pwm; it.exp_flag = m_flag; it.tag = tag;
    q.push_back(it);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic [15:0] cnt, input string tag);
    step(cnt, cnt == 16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, tag);
  endtask

  task automatic load(input logic [15:0] v, input string tag);
    step(16'h7777, 1'b0, 1'b1, 1'b0, v[7:0], 1'b0, tag);
    step(16'h7777, 1'b0, 1'b0, 1'b1, v[15:8], 1'b0, tag);
  endtask

  initial begin
    rst_n = 1'b0; tb_count = '0; tb_ovf = 0; wr_lo = 0; wr_hi = 0;
    wr_data = '0; mode_pwm = 1; mode_wide = 1; match_en = 1; flag_clr = 0;
    m_cmp = '0; m_en = 0; m_pwm = 0; m_flag = 0;
    repeat (3) @(posedge clk);
    #1;
    check(pwm_o, 1'b0, "R10 reset pwm");
    check(match_flag_o, 1'b0, "R10 reset flag");
    @(negedge clk);
    rst_n = 1'b1;
    // R10: compare 0 disabled after reset, count 0 with ovf gives no set
    idle(16'h0000, "R10 disabled after reset");

    // R1/R2/R6/R11: load 0x1234
    load(16'h1234, "R6 load");
    idle(16'h1233, "R1 before match");
    idle(16'h1234, "R1 match sets");
    idle(16'h1235, "R1 holds high");
    idle(16'h0000, "R2 overflow clears");
    idle(16'h0001, "R2 holds low");

    // R9: flag sticky, then cleared
    idle(16'h0002, "R9 sticky");
    step(16'h0003, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R9 clear");
    // R9: clear loses to match
    step(16'h1234, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R9 match beats clear");

    // R11: write in match cycle compares old value
    step(16'h1234, 1'b0, 1'b1, 1'b1, 8'h50, 1'b1, "R11 old value used");
    idle(16'h0000, "R11 clear by ovf");
    idle(16'h1234, "R11 old value gone");
    idle(16'h5050, "R6 both strobes armed");
    idle(16'h0000, "R2 wrap");

    // R5: low byte write alone disarms, pin falls at ovf, then stays low
    step(16'h0100, 1'b0, 1'b1, 1'b0, 8'h20, 1'b1, "R5 low write");
    idle(16'h5020, "R5 no match while disarmed");
    idle(16'h5050, "R5 old value no match");
    idle(16'h0000, "R5 ovf");
    idle(16'h5020, "R5 stays low");
    step(16'h0005, 1'b0, 1'b0, 1'b1, 8'h50, 1'b0, "R6 rearm");
    idle(16'h5020, "R6 match after rearm");

    // R3: compare 0 stays high across overflow
    load(16'h0000, "R3 load zero");
    idle(16'h0000, "R3 match and ovf");
    for (int i = 1; i < 6; i++) idle(16'(i), "R3 stays high");
    idle(16'h0000, "R3 second wrap");

    // R4: compare 0xFFFF, single clock high
    load(16'hFFFF, "R4 load");
    idle(16'h0000, "R4 low at wrap");
    idle(16'hFFFE, "R4 still low");
    idle(16'hFFFF, "R4 high one clock");
    idle(16'h0000, "R4 low again");
    idle(16'h0001, "R4 stays low");

    // R7: mode bits gate matching
    load(16'h0040, "R7 load");
    mode_wide = 0;
    idle(16'h0040, "R7 wide off no match");
    mode_wide = 1; mode_pwm = 0;
    idle(16'h0040, "R7 pwm off no match");
    mode_pwm = 1;
    idle(16'h0040, "R7 both on match");
    idle(16'h0000, "R7 wrap");

    // R8: match_en off, pin sets but flag unchanged
    step(16'h0001, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R8 clear flag");
    match_en = 0;
    idle(16'h0040, "R8 pin without flag");
    idle(16'h0000, "R8 wrap");
    match_en = 1;

    // R1/R2 sweep across a wrap with compare 0x0005
    load(16'h0005, "R1 sweep load");
    for (int i = 0; i < 40; i++) begin
      logic [15:0] c;
      c = 16'hFFEC + 16'(i);
      idle(c, "R1 R2 sweep");
    end

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_total++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule